// File: doc/BRIEF.md
# Writeback Capture Control Register Block

This block holds the software-visible configuration of a display writeback engine and sequences its frames. Software reaches it through a simple 32-bit word register bus, using a 3-bit word index: destination base address (word 0, byte 0x00), line pitch (word 1, byte 0x04), image dimensions (word 2, byte 0x08), control word (word 3, byte 0x0C) and committed-line count (word 4, byte 0x10). Reads are combinational, and word indices 5 to 7 read zero. The stored fields drive the address generator and the pixel packer directly.

A small sequencer with three states controls each frame. In SEQ_IDLE nothing is in flight. A go request moves it to SEQ_RUN (transition START) and sends a one-cycle frame request upstream. In SEQ_RUN, an end-of-frame input returns it to SEQ_IDLE (transition FINISH), and an abort request moves it to SEQ_DRAIN (transition ABORT). In SEQ_DRAIN the abort output is held high until the datapath reports that no writes are outstanding (transition DRAINED) or a bounded cycle count runs out (transition TIMEOUT). Both of these go to SEQ_IDLE. When an enabled frame returns to idle, a level interrupt is latched.

Top module: `wb_capture_ctrl`

## Requirements
- R1: After reset, words 0, 1, 2 and 4 read 0. The control word reads 0x5440_0000. busy, irq, frame_req, abort_req and power_down are all 0.
- R2: Words 0 and 1 read back the last value written. In word 2, bits [15:0] drive img_width and bits [31:16] drive img_height, and the word reads back as written.
- R3: In the control word, bits [31:24] always read 0x54 and bits [23:22] always read 2'b01, whatever is written. Bits 0 (go) and 14 (abort) always read 0. Bit 1 reads the busy state.
- R4: A control write with bit 0 set and bit 21 clear, made while idle, sets busy from the next cycle. That write also pulses frame_req for exactly that cycle and clears the line count.
- R5: A go write is ignored when the sequencer is busy, and also when the same write sets bit 21. In both cases there is no frame_req pulse and no change of state.
- R6: While running, frame_end returns the block to idle on the next cycle. If bit 15 is set, frame_req pulses again in that same cycle.
- R7: A control write with bit 14 set while running raises abort_req from the next cycle, and busy stays high. Both clear one cycle after wr_idle is seen, or after ABORT_LIMIT cycles in the drain state, whichever comes first. frame_end has priority over abort in the same cycle.
- R8: When the block returns to idle while bit 2 is held set, irq rises in the same cycle that busy falls. irq then stays high until a control write with bit 2 clear, or until an accepted go.
- R9: Word 4 counts line_commit pulses received while busy. Writes to word 4 are ignored.
- R10: power_down follows control bit 21 from the cycle after the write.
- R11: Control bits drive the configuration outputs as follows: [11:8] pix_fmt, 20 alpha_en, 12 alpha_inv, [19:16] byte_en, 13 dither_en, [7:3] layout_mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| frame_end | input | 1 | Datapath finished the frame |
| line_commit | input | 1 | One line committed to memory |
| wr_idle | input | 1 | No memory writes outstanding |
| frame_req | output | 1 | Frame-start request pulse to the upstream compositor |
| abort_req | output | 1 | Stop memory writes immediately |
| power_down | output | 1 | Power down the internal buffer memory |
| busy | output | 1 | A frame is in progress |
| irq | output | 1 | Level interrupt on return to idle |
| dst_ptr | output | 32 | Destination base address |
| dst_pitch | output | 32 | Line pitch |
| img_width | output | DIM_W | Image width |
| img_height | output | DIM_W | Image height |
| pix_fmt | output | 4 | Pixel format code |
| alpha_en | output | 1 | Store alpha component |
| alpha_inv | output | 1 | Invert alpha, or select the fill value |
| byte_en | output | 4 | Per-byte store enables |
| dither_en | output | 1 | Dither enable |
| layout_mode | output | 5 | Tiling, rotation, test and field bits |

## Verification
The bench writes junk into the identification bits and into the go bit together with power-down. A design that stored those bits would read them back wrongly, and one that ignored power-down would start a frame. It issues go in the middle of a frame, which a design without the busy guard would answer with a fresh frame request and a cleared line count. It drains an abort both through wr_idle and through the timeout. A design with a missing or off-by-one bound would hold busy for the wrong number of cycles. It also checks that the interrupt holds until it is cleared by disabling it or by starting a new frame, which catches designs that pulse the interrupt or never release it.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_RUN   = 2'd1,
        SEQ_DRAIN = 2'd2
    } seq_state_t;

    localparam int REG_PTR   = 0;
    localparam int REG_PITCH = 1;
    localparam int REG_DIM   = 2;
    localparam int REG_CTRL  = 3;
    localparam int REG_PROG  = 4;

    localparam int B_GO     = 0;
    localparam int B_IE     = 2;
    localparam int B_ABORT  = 14;
    localparam int B_REARM  = 15;
    localparam int B_PDN    = 21;

    localparam logic [7:0] ID_HI = 8'h54;
    localparam logic [1:0] ID_LO = 2'b01;
    // writable control slice covers bits [21:2]; the abort position stays 0
    localparam logic [19:0] CTRL_WMASK = 20'hFEFFF;
endpackage

// File: rtl/wbc_regfile.sv
module wbc_regfile
    import wbc_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DIM_W  = 16,
    parameter int PROG_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    input  logic [PROG_W-1:0] progress,
    output logic [DATA_W-1:0] rdata,
    output logic              ctrl_wr,
    output logic [DATA_W-1:0] ptr_q,
    output logic [DATA_W-1:0] pitch_q,
    output logic [DIM_W-1:0]  width_q,
    output logic [DIM_W-1:0]  height_q,
    output logic [19:0]       ctrl_q
);
    localparam int HALF = DATA_W / 2;

    logic sel_ptr, sel_pitch, sel_dim;

    always_comb begin
        sel_ptr   = wr_en && (addr == ADDR_W'(REG_PTR));
        sel_pitch = wr_en && (addr == ADDR_W'(REG_PITCH));
        sel_dim   = wr_en && (addr == ADDR_W'(REG_DIM));
        ctrl_wr   = wr_en && (addr == ADDR_W'(REG_CTRL));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            pitch_q  <= '0;
            width_q  <= '0;
            height_q <= '0;
            ctrl_q   <= '0;
        end else begin
            if (sel_ptr)   ptr_q   <= wdata;
            if (sel_pitch) pitch_q <= wdata;
            if (sel_dim) begin
                width_q  <= wdata[DIM_W-1:0];
                height_q <= wdata[HALF+DIM_W-1:HALF];
            end
            if (ctrl_wr)   ctrl_q  <= wdata[21:2] & CTRL_WMASK;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_W'(REG_PTR):   rdata = ptr_q;
            ADDR_W'(REG_PITCH): rdata = pitch_q;
            ADDR_W'(REG_DIM): begin
                rdata[DIM_W-1:0]           = width_q;
                rdata[HALF+DIM_W-1:HALF]   = height_q;
            end
            ADDR_W'(REG_CTRL):  rdata = {ID_HI, ID_LO, ctrl_q, busy, 1'b0};
            ADDR_W'(REG_PROG):  rdata[PROG_W-1:0] = progress;
            default:            rdata = '0;
        endcase
    end
endmodule

// File: rtl/wbc_seq.sv
module wbc_seq
    import wbc_pkg::*;
#(
    parameter int ABORT_LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic wr_go,
    input  logic wr_abort,
    input  logic wr_pdn,
    input  logic wr_ie,
    input  logic ie_q,
    input  logic rearm_q,
    input  logic frame_end,
    input  logic wr_idle,
    output logic go_ok,
    output logic busy,
    output logic abort_req,
    output logic frame_req,
    output logic irq
);
    localparam int CNT_W = $clog2(ABORT_LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ABORT_LIMIT - 1);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             req_d, finish;

    always_comb go_ok = ctrl_wr && wr_go && !wr_pdn && (state_q == SEQ_IDLE);

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        req_d   = 1'b0;
        finish  = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (go_ok) begin            // START
                    state_d = SEQ_RUN;
                    req_d   = 1'b1;
                end
            end
            SEQ_RUN: begin
                if (frame_end) begin        // FINISH
                    state_d = SEQ_IDLE;
                    req_d   = rearm_q;
                    finish  = 1'b1;
                end else if (ctrl_wr && wr_abort) begin  // ABORT
                    state_d = SEQ_DRAIN;
                    cnt_d   = '0;
                end
            end
            SEQ_DRAIN: begin
                if (wr_idle || cnt_q == CNT_LAST) begin  // DRAINED / TIMEOUT
                    state_d = SEQ_IDLE;
                    finish  = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_req <= 1'b0;
            irq       <= 1'b0;
        end else begin
            frame_req <= req_d;
            if (go_ok || (ctrl_wr && !wr_ie))
                irq <= 1'b0;
            else if (finish && ie_q)
                irq <= 1'b1;
        end
    end

    always_comb begin
        busy      = (state_q != SEQ_IDLE);
        abort_req = (state_q == SEQ_DRAIN);
    end
endmodule

// File: rtl/wbc_progress.sv
module wbc_progress #(
    parameter int PROG_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              busy,
    input  logic              line_commit,
    output logic [PROG_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= '0;
        else if (busy && line_commit)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/wb_capture_ctrl.sv
module wb_capture_ctrl
    import wbc_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int DIM_W       = 16,
    parameter int PROG_W      = 16,
    parameter int ABORT_LIMIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              frame_end,
    input  logic              line_commit,
    input  logic              wr_idle,
    output logic              frame_req,
    output logic              abort_req,
    output logic              power_down,
    output logic              busy,
    output logic              irq,
    output logic [31:0]       dst_ptr,
    output logic [31:0]       dst_pitch,
    output logic [DIM_W-1:0]  img_width,
    output logic [DIM_W-1:0]  img_height,
    output logic [3:0]        pix_fmt,
    output logic              alpha_en,
    output logic              alpha_inv,
    output logic [3:0]        byte_en,
    output logic              dither_en,
    output logic [4:0]        layout_mode
);
    logic              ctrl_wr, go_ok;
    logic [19:0]       ctrl_q;   // control bits [21:2]
    logic [PROG_W-1:0] prog_cnt;

    wbc_regfile #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .PROG_W(PROG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .addr(bus_addr),
        .wdata(bus_wdata), .busy(busy), .progress(prog_cnt),
        .rdata(bus_rdata), .ctrl_wr(ctrl_wr), .ptr_q(dst_ptr),
        .pitch_q(dst_pitch), .width_q(img_width), .height_q(img_height),
        .ctrl_q(ctrl_q)
    );

    wbc_seq #(.ABORT_LIMIT(ABORT_LIMIT)) u_seq (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
        .wr_go(bus_wdata[B_GO]), .wr_abort(bus_wdata[B_ABORT]),
        .wr_pdn(bus_wdata[B_PDN]), .wr_ie(bus_wdata[B_IE]),
        .ie_q(ctrl_q[B_IE-2]), .rearm_q(ctrl_q[B_REARM-2]),
        .frame_end(frame_end), .wr_idle(wr_idle), .go_ok(go_ok),
        .busy(busy), .abort_req(abort_req), .frame_req(frame_req), .irq(irq)
    );

    wbc_progress #(.PROG_W(PROG_W)) u_prog (
        .clk(clk), .rst_n(rst_n), .clear(go_ok), .busy(busy),
        .line_commit(line_commit), .count(prog_cnt)
    );

    always_comb begin
        power_down  = ctrl_q[B_PDN-2];
        alpha_en    = ctrl_q[18];
        byte_en     = ctrl_q[17:14];
        dither_en   = ctrl_q[11];
        alpha_inv   = ctrl_q[10];
        pix_fmt     = ctrl_q[9:6];
        layout_mode = ctrl_q[5:1];
    end
endmodule

// File: rtl/wb_capture_ctrl_chk.sv
module wb_capture_ctrl_chk #(
    parameter int ADDR_W      = 3,
    parameter int PROG_W      = 16,
    parameter int ABORT_LIMIT = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              busy,
    input logic              irq,
    input logic              frame_req,
    input logic              abort_req,
    input logic              wr_idle,
    input logic              power_down,
    input logic [PROG_W-1:0] progress
);
    localparam int CW = $clog2(ABORT_LIMIT + 2);
    logic [CW-1:0] drain_cycles;
    logic          ctrl_wr;

    always_comb ctrl_wr = bus_wr_en && (bus_addr == ADDR_W'(3));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         drain_cycles <= '0;
        else if (abort_req) drain_cycles <= drain_cycles + 1'b1;
        else                drain_cycles <= '0;
    end

    AST_START_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> frame_req);                                         // R4
    AST_PDN_BLOCKS_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[0] && bus_wdata[21] && !busy) |=> !busy);      // R5
    AST_DRAIN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_req && wr_idle) |=> !busy);                                  // R7
    AST_DRAIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |-> (drain_cycles < CW'(ABORT_LIMIT)));                   // R7
    AST_IRQ_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $fell(busy));                                        // R8
    AST_PROG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (progress == '0));                                  // R9
    AST_PDN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (power_down == $past(bus_wdata[21])));                  // R10
endmodule

bind wb_capture_ctrl wb_capture_ctrl_chk #(
    .ADDR_W(ADDR_W), .PROG_W(PROG_W), .ABORT_LIMIT(ABORT_LIMIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .busy(busy), .irq(irq), .frame_req(frame_req),
    .abort_req(abort_req), .wr_idle(wr_idle), .power_down(power_down),
    .progress(prog_cnt)
);

// File: tb/wb_capture_ctrl_bench.sv
module wb_capture_ctrl_bench;
    localparam int LIMIT = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        frame_end = 1'b0, line_commit = 1'b0, wr_idle = 1'b0;
    logic        frame_req, abort_req, power_down, busy, irq;
    logic [31:0] dst_ptr, dst_pitch;
    logic [15:0] img_width, img_height;
    logic [3:0]  pix_fmt, byte_en;
    logic        alpha_en, alpha_inv, dither_en;
    logic [4:0]  layout_mode;

    int checks = 0, failures = 0;

    always #5 clk = ~clk;

    wb_capture_ctrl #(.ABORT_LIMIT(LIMIT)) u_wb_capture_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_end(frame_end),
        .line_commit(line_commit), .wr_idle(wr_idle), .frame_req(frame_req),
        .abort_req(abort_req), .power_down(power_down), .busy(busy), .irq(irq),
        .dst_ptr(dst_ptr), .dst_pitch(dst_pitch), .img_width(img_width),
        .img_height(img_height), .pix_fmt(pix_fmt), .alpha_en(alpha_en),
        .alpha_inv(alpha_inv), .byte_en(byte_en), .dither_en(dither_en),
        .layout_mode(layout_mode)
    );

    // reference model
    int          m_mode;      // 0 idle, 1 running, 2 draining
    int          m_wait;
    bit          m_req, m_irq;
    int          m_lines;
    logic [31:0] m_ptr, m_pitch, m_dim, m_ctrl;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_wait = 0; m_req = 0; m_irq = 0; m_lines = 0;
            m_ptr = 0; m_pitch = 0; m_dim = 0; m_ctrl = 0;
        end else begin
            bit cw, start, done;
            cw    = bus_wr_en && bus_addr == 3'd3;
            start = cw && bus_wdata[0] && !bus_wdata[21] && m_mode == 0;
            done  = 0;
            m_req = 0;
            if (m_mode != 0 && line_commit) m_lines = (m_lines + 1) % 65536;
            if (m_mode == 1 && frame_end) begin
                m_mode = 0; done = 1; m_req = m_ctrl[15];
            end else if (m_mode == 1 && cw && bus_wdata[14]) begin
                m_mode = 2; m_wait = 0;
            end else if (m_mode == 2) begin
                m_wait++;
                if (wr_idle || m_wait == LIMIT) begin m_mode = 0; done = 1; end
            end else if (start) begin
                m_mode = 1; m_req = 1; m_lines = 0;
            end
            if (start || (cw && !bus_wdata[2])) m_irq = 0;
            else if (done && m_ctrl[2]) m_irq = 1;
            if (bus_wr_en) case (bus_addr)
                3'd0: m_ptr = bus_wdata;
                3'd1: m_pitch = bus_wdata;
                3'd2: m_dim = bus_wdata;
                3'd3: m_ctrl = bus_wdata & 32'h003F_BFFC;
                default: ;
            endcase
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_rd(logic [2:0] a);
        case (a)
            3'd0: return m_ptr;
            3'd1: return m_pitch;
            3'd2: return m_dim;
            3'd3: return {8'h54, 2'b01, m_ctrl[21:2], m_mode != 0, 1'b0};
            3'd4: return {16'h0, 16'(m_lines)};
            default: return 32'h0;
        endcase
    endfunction

    always @(negedge clk) begin
        chk("R4 busy", {31'h0, busy}, {31'h0, m_mode != 0});
        chk("R4/R6 frame_req", {31'h0, frame_req}, {31'h0, m_req});
        chk("R7 abort_req", {31'h0, abort_req}, {31'h0, m_mode == 2});
        chk("R8 irq", {31'h0, irq}, {31'h0, m_irq});
        chk("R10 power_down", {31'h0, power_down}, {31'h0, m_ctrl[21]});
        chk("R2/R3/R9 rdata", bus_rdata, exp_rd(bus_addr));
        chk("R2 dims", {img_height, img_width}, m_dim);
        chk("R2 ptr", dst_ptr ^ dst_pitch, m_ptr ^ m_pitch);
        chk("R11 cfg", {15'h0, alpha_en, byte_en, dither_en, alpha_inv, pix_fmt, layout_mode},
            {15'h0, m_ctrl[20], m_ctrl[19:16], m_ctrl[13], m_ctrl[12], m_ctrl[11:8], m_ctrl[7:3]});
    end

    task automatic step(int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        bus_wr_en = 1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr_en = 0;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        step(2);
        bus_addr = 3'd3; #1;
        chk("R1 ctrl reset", bus_rdata, 32'h5440_0000);
        rst_n = 1; step();
        // R2 plain registers
        wr(3'd0, 32'hDEAD_BEE0); wr(3'd1, 32'h0000_1E00); wr(3'd2, 32'h0438_0780);
        bus_addr = 3'd0; step(); bus_addr = 3'd1; step(); bus_addr = 3'd2; step();
        chk("R2 width", {16'h0, img_width}, 32'h780);
        // R5 go together with power-down, junk in id bits
        wr(3'd3, 32'hFFFF_BFFF); step();
        chk("R5 no start with pdn", {31'h0, busy}, 32'h0);
        chk("R10 pdn set", {31'h0, power_down}, 32'h1);
        // R4 start a rearming, interrupting frame
        wr(3'd3, 32'h001F_AD05);
        chk("R4 started", {31'h0, busy}, 32'h1);
        bus_addr = 3'd4;
        for (int i = 0; i < 5; i++) begin line_commit = 1; step(); line_commit = 0; step(); end
        chk("R9 lines", bus_rdata, 32'd5);
        wr(3'd3, 32'h001F_AD05);   // R5 go while busy
        bus_addr = 3'd4; step();
        chk("R5 lines kept", bus_rdata, 32'd5);
        wr(3'd4, 32'h0000_FFFF);   // R9 write ignored
        bus_addr = 3'd4; step();
        chk("R9 write ignored", bus_rdata, 32'd5);
        frame_end = 1; step(); frame_end = 0;
        chk("R6 rearm pulse", {31'h0, frame_req}, 32'h1);
        chk("R8 irq raised", {31'h0, irq}, 32'h1);
        step(3);
        chk("R8 irq held", {31'h0, irq}, 32'h1);
        wr(3'd3, 32'h0000_0100); step();
        chk("R8 irq cleared by ie=0", {31'h0, irq}, 32'h0);
        // R7 abort drained by wr_idle
        wr(3'd3, 32'h0000_0005); step(2);
        wr(3'd3, 32'h0000_4004);
        chk("R7 abort raised", {31'h0, abort_req}, 32'h1);
        step(3); wr_idle = 1; step(); wr_idle = 0;
        chk("R7 drained", {31'h0, busy}, 32'h0);
        // R8 go clears irq; R7 abort by timeout
        wr(3'd3, 32'h0000_0005);
        chk("R8 irq cleared by go", {31'h0, irq}, 32'h0);
        wr(3'd3, 32'h0000_4004);
        step(LIMIT - 1);
        chk("R7 still draining", {31'h0, busy}, 32'h1);
        step();
        chk("R7 timeout idle", {31'h0, busy}, 32'h0);
        // R7 frame_end wins over abort
        wr(3'd3, 32'h0000_0001);
        bus_wr_en = 1; bus_addr = 3'd3; bus_wdata = 32'h0000_4000; frame_end = 1;
        step(); bus_wr_en = 0; frame_end = 0;
        chk("R7 frame_end priority", {31'h0, abort_req}, 32'h0);
        step(3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule